// File: doc/BRIEF.md
# Selectable-Length Periodic Interrupt Divider

This block is a binary up counter that runs from a slow sub-oscillator enable tick and raises a periodic interrupt. A select bit sets the count length at run time. The short length (13 bits by default) gives one overflow every 8192 ticks. The long length (14 bits by default) gives one overflow every 16384 ticks. With a 32768 Hz tick these periods are a quarter second and half a second.

A run bit starts counting. While the run bit is low, the counter is forced to zero and ignores ticks. Each overflow sets a sticky interrupt flag, and the flag drives a level interrupt request. Software clears the flag with a clear strobe. The flag is also cleared by an acknowledge pulse from the interrupt service path. If an overflow and a clear fall in the same cycle, the overflow wins.

Top module: `per_irq_divider`

## Requirements
- R1: After reset, irq_flag_o and irq_req_o are 0 and the count is zero.
- R2: With len_sel_i=0 (short length, SHORT_W=13 bits), a count started from zero sets the flag on the 8192nd counted tick and not on the 8191st.
- R3: With len_sel_i=1 (long length, LONG_W=14 bits), a count started from zero sets the flag on the 16384th counted tick and not on the 16383rd.
- R4: While run_i=0 the counter is held at zero and ticks are not counted. After run_i returns to 1, a full period is needed for the next overflow.
- R5: A clock cycle with tick_i=0 does not advance the counter.
- R6: The counter wraps to zero on overflow, so the next overflow comes exactly one full period later.
- R7: The flag is sticky. It stays set with no clear, including while run_i is low.
- R8: A one-cycle pulse on sw_clr_i clears the flag on that clock edge.
- R9: A one-cycle pulse on svc_ack_i clears the flag on that clock edge.
- R10: If an overflow and a clear occur in the same cycle, the flag is set after that edge.
- R11: A change of len_sel_i while counting does not reset the count. In short mode, overflow happens when the low SHORT_W bits are all ones. In long mode, overflow happens when all LONG_W bits are all ones.
- R12: irq_req_o equals irq_flag_o at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sub-oscillator enable tick, one cycle wide |
| len_sel_i | input | 1 | Length select: 0 short, 1 long |
| run_i | input | 1 | 1 counts, 0 holds the counter at zero |
| sw_clr_i | input | 1 | Software clear strobe for the flag |
| svc_ack_i | input | 1 | Service-entry acknowledge, clears the flag |
| irq_flag_o | output | 1 | Sticky overflow flag |
| irq_req_o | output | 1 | Level interrupt request |

## Verification
The overflow detect is combinational on the counter register. The flag therefore changes on the same clock edge that samples the final tick. A clear pulse also acts on the edge that samples it, and a run-low cycle zeroes the counter on the next edge. The bench drives inputs at the falling edge and keeps tick_i high for exactly N rising edges. It then samples at the following falling edge, so each check lands one half period after the edge that owns the result. Boundaries are checked as pairs: one tick before the expected overflow, where the flag must still be clear, and the overflow tick itself.

// File: rtl/div_pkg.sv
package div_pkg;
   typedef enum logic {
      LEN_SHORT = 1'b0,
      LEN_LONG  = 1'b1
   } len_e;

   localparam int unsigned NUM_LENGTHS = 2;
endpackage

// File: rtl/div_counter.sv
module div_counter
   import div_pkg::*;
#(
   parameter int unsigned SHORT_W = 13,
   parameter int unsigned LONG_W  = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   input  logic len_sel_i,
   output logic wrap_o
);
   localparam logic [LONG_W-1:0] ONE  = LONG_W'(1);
   localparam logic [LONG_W-1:0] ZERO = '0;

   initial begin
      assert (SHORT_W >= 2) else $error("SHORT_W must be at least 2");
      assert (LONG_W > SHORT_W) else $error("LONG_W must exceed SHORT_W");
   end

   logic [LONG_W-1:0]      cnt_q;
   logic [NUM_LENGTHS-1:0] full;
   logic                   step;
   logic                   at_end;

   for (genvar m = 0; m < NUM_LENGTHS; m++) begin : g_len
      localparam int unsigned W = (m == 0) ? SHORT_W : LONG_W;
      assign full[m] = &cnt_q[W-1:0];
   end

   assign step   = run_i & tick_i;
   assign at_end = (len_e'(len_sel_i) == LEN_LONG) ? full[1] : full[0];
   assign wrap_o = step & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= ZERO;
      else if (!run_i) cnt_q <= ZERO;
      else if (wrap_o) cnt_q <= ZERO;
      else if (step)   cnt_q <= cnt_q + ONE;
   end

   // R4
   hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == ZERO));
   // R5
   no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !tick_i) |=> $stable(cnt_q));
   // R6
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == ZERO));
   // R11
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wrap_o) |=> (cnt_q == $past(cnt_q) + ONE));
endmodule

// File: rtl/div_flag.sv
module div_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic sw_clr_i,
   input  logic svc_ack_i,
   output logic flag_o
);
   logic clr;
   assign clr = sw_clr_i | svc_ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr)   flag_o <= 1'b0;
   end

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R8
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_i) |=> !flag_o);
   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/per_irq_divider.sv
module per_irq_divider #(
   parameter int unsigned SHORT_W = 13,
   parameter int unsigned LONG_W  = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic len_sel_i,
   input  logic run_i,
   input  logic sw_clr_i,
   input  logic svc_ack_i,
   output logic irq_flag_o,
   output logic irq_req_o
);
   logic wrap;

   div_counter #(
      .SHORT_W (SHORT_W),
      .LONG_W  (LONG_W)
   ) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_i),
      .tick_i    (tick_i),
      .len_sel_i (len_sel_i),
      .wrap_o    (wrap)
   );

   div_flag flag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (wrap),
      .sw_clr_i  (sw_clr_i),
      .svc_ack_i (svc_ack_i),
      .flag_o    (irq_flag_o)
   );

   assign irq_req_o = irq_flag_o;

   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_ack_i && !wrap) |=> !irq_flag_o);
   // R12
   req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o == irq_flag_o);
endmodule

// File: tb/per_irq_divider_tb.sv
module per_irq_divider_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 195000;
   localparam int NV         = 6;
   localparam int V_MODE [NV] = '{0, 0, 1, 1, 1, 0};
   localparam int V_TICKS[NV] = '{8191, 8192, 8192, 16383, 16384, 1};
   localparam int V_EXP  [NV] = '{0, 1, 0, 0, 1, 0};

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_i = 1'b0, len_sel_i = 1'b0, run_i = 1'b0;
   logic sw_clr_i = 1'b0, svc_ack_i = 1'b0;
   logic irq_flag_o, irq_req_o;
   int   errors = 0, checks = 0;
   bit   done = 1'b0;

   per_irq_divider dut_i (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input logic exp, input string tag);
      checks++;
      if (irq_flag_o !== exp || irq_req_o !== exp) begin
         errors++;
         $display("FAIL %s: flag=%b req=%b expected=%b", tag, irq_flag_o, irq_req_o, exp);
      end
   endtask

   task automatic run_ticks(input int n);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic restart(input logic mode);
      run_i = 1'b0; sw_clr_i = 1'b1; len_sel_i = mode;
      @(negedge clk);
      run_i = 1'b1; sw_clr_i = 1'b0;
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: finished=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(1'b0, "R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(1'b0, "R1 after release");

      // table: R2 short length, R3 long length
      for (int i = 0; i < NV; i++) begin
         restart(V_MODE[i][0]);
         run_ticks(V_TICKS[i]);
         chk(V_EXP[i][0], V_MODE[i] == 0 ? "R2 short vector" : "R3 long vector");
      end

      // R7 sticky while stopped
      restart(1'b0);
      run_ticks(8192);
      run_i = 1'b0;
      repeat (100) @(negedge clk);
      chk(1'b1, "R7 sticky with run low");

      // R4 run low ignores ticks, restart from zero
      sw_clr_i = 1'b1; @(negedge clk); sw_clr_i = 1'b0;
      run_ticks(9000);
      chk(1'b0, "R4 ticks while stopped");
      run_i = 1'b1;
      run_ticks(8191);
      chk(1'b0, "R4 full period after restart");
      run_ticks(1);
      chk(1'b1, "R4 overflow after restart");

      // R5 idle cycles do not count
      restart(1'b0);
      repeat (100) @(negedge clk);
      run_ticks(8191);
      chk(1'b0, "R5 idle cycles not counted");
      run_ticks(1);
      chk(1'b1, "R5 overflow on tick 8192");

      // R10 overflow and clear together
      restart(1'b0);
      run_ticks(8191);
      chk(1'b0, "R10 before collision");
      tick_i = 1'b1; sw_clr_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0; sw_clr_i = 1'b0;
      chk(1'b1, "R10 overflow beats clear");

      // R9 service acknowledge clears
      svc_ack_i = 1'b1; @(negedge clk); svc_ack_i = 1'b0;
      chk(1'b0, "R9 ack clears");

      // R6 wrap to zero: next overflow one full period later
      run_ticks(8191);
      chk(1'b0, "R6 one tick short of period");
      run_ticks(1);
      chk(1'b1, "R6 second overflow");

      // R8 software clear
      sw_clr_i = 1'b1; @(negedge clk); sw_clr_i = 1'b0;
      chk(1'b0, "R8 software clear");

      // R11 short to long at count 5000: overflow at count 16383
      restart(1'b0);
      run_ticks(5000);
      len_sel_i = 1'b1;
      run_ticks(3192);
      chk(1'b0, "R11 long select in effect");
      run_ticks(8191);
      chk(1'b0, "R11 count kept, one short");
      run_ticks(1);
      chk(1'b1, "R11 long overflow");

      // R11 long to short at count 3000: overflow 5192 ticks later
      restart(1'b1);
      run_ticks(3000);
      len_sel_i = 1'b0;
      run_ticks(5191);
      chk(1'b0, "R11 short one tick before");
      run_ticks(1);
      chk(1'b1, "R11 short overflow, R12 level");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule